// File: doc/BRIEF.md
# Byte-Stuffed Frame Receiver with CRC16 Check

This block sits behind a UART receiver and takes its output one byte per strobe. It finds frames by their marker bytes, removes the escape sequences, and passes the decoded payload to a consumer, one byte per `out_valid` strobe. A running CRC16 is kept over the payload. At the end marker, the last two decoded bytes are compared with that CRC and the block reports the result.

Every frame begins with the start marker 0x8E and closes with the end marker 0xAE. The escape byte 0x9E tells the receiver to translate the byte that follows, so that a marker or escape value can appear inside the data. The payload output runs two decoded bytes behind the input. Because of this hold-back, the two trailing CRC bytes are never shown to the consumer as payload. The frame status comes out on four signals: a frame-active level, a one-cycle completion pulse, a CRC-mismatch flag and a framing-error flag.

Top module: `stuffed_frame_rx`

## Requirements
- R1: An input byte 0x8E starts a frame. `pkt_run` goes high and `crc_err` and `frame_err` are cleared. This also happens when a frame is already running.
- R2: Inside a frame, the escape byte 0x9E followed by 0x81 decodes to 0x8E, followed by 0xA1 decodes to 0xAE, and followed by 0x91 decodes to 0x9E.
- R3: Each decoded byte of a frame, except the last two, appears once on `out_byte` with a one-cycle `out_valid`. Bytes appear in arrival order.
- R4: The CRC16 uses polynomial 0x1021, is computed MSB first, has no final XOR, and is seeded with 0x1D0F at each start marker. It covers the payload bytes. At the end marker, `crc_err` goes high when the last two decoded bytes (the first of them is the high byte) differ from the CRC. Otherwise `crc_err` stays low.
- R5: An end marker 0xAE in a frame that holds at least two decoded bytes gives a one-cycle `pkt_done` pulse and drops `pkt_run`.
- R6: An escape byte followed by a byte other than 0x81, 0xA1, 0x91 or 0x8E sets `frame_err` and drops `pkt_run`. It gives no `pkt_done`, and the bytes that follow produce no output until the next start marker.
- R7: A start marker inside a frame discards the partial frame. Bytes still held back are never emitted.
- R8: Bytes received outside a frame, including 0xAE and 0x9E, produce no `out_valid` and leave `pkt_run` low.
- R9: An end marker in a frame holding fewer than two decoded bytes sets `frame_err`, gives no `pkt_done`, and leaves `crc_err` low.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe for a received byte |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Strobe for a decoded payload byte |
| out_byte | output | 8 | Decoded payload byte |
| pkt_run | output | 1 | High while a frame is being received |
| pkt_done | output | 1 | One-cycle pulse when a frame completes |
| crc_err | output | 1 | CRC of the last completed frame did not match |
| frame_err | output | 1 | Last frame had a bad escape or was too short |

## Verification
A decoder left in the escape state, or one that thinks it is outside a frame, shows up within one or two cycles of the next byte. The symptom is a wrongly translated or missing payload byte, which the scoreboard notices on its next comparison. If the hold-back count or the CRC register goes wrong, the fault only appears at the end marker: CRC bytes leak out as payload, a byte goes missing, or `crc_err` or `frame_err` takes the wrong value two cycles after the end marker. Because of this, the stimulus includes frames that carry every special value, frames with a corrupted CRC, frames that are aborted, restarted or too short, and a frame that carries nothing but its CRC.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_ESC
    } dec_state_e;
endpackage

// File: rtl/sfr_decode.sv
module sfr_decode
    import sfr_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter [BYTE_W-1:0] SOF     = 8'h8E,
    parameter [BYTE_W-1:0] EOF     = 8'hAE,
    parameter [BYTE_W-1:0] ESC     = 8'h9E,
    parameter [BYTE_W-1:0] SUB_SOF = 8'h81,
    parameter [BYTE_W-1:0] SUB_EOF = 8'hA1,
    parameter [BYTE_W-1:0] SUB_ESC = 8'h91
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              dec_start,
    output logic              dec_data,
    output logic              dec_fin,
    output logic              dec_abort,
    output logic [BYTE_W-1:0] dec_byte
);
    typedef struct packed {
        dec_state_e        st;
        logic              start;
        logic              data;
        logic              fin;
        logic              abort;
        logic [BYTE_W-1:0] value;
    } dec_s;

    dec_s dec_d, dec_q;

    always_comb begin
        dec_d       = dec_q;
        dec_d.start = 1'b0;
        dec_d.data  = 1'b0;
        dec_d.fin   = 1'b0;
        dec_d.abort = 1'b0;
        if (in_valid) begin
            if (in_byte == SOF) begin
                dec_d.start = 1'b1;
                dec_d.st    = ST_BODY;
            end else begin
                unique case (dec_q.st)
                    ST_BODY: begin
                        if (in_byte == EOF) begin
                            dec_d.fin = 1'b1;
                            dec_d.st  = ST_IDLE;
                        end else if (in_byte == ESC) begin
                            dec_d.st = ST_ESC;
                        end else begin
                            dec_d.data  = 1'b1;
                            dec_d.value = in_byte;
                        end
                    end
                    ST_ESC: begin
                        dec_d.st = ST_BODY;
                        if (in_byte == SUB_SOF) begin
                            dec_d.data  = 1'b1;
                            dec_d.value = SOF;
                        end else if (in_byte == SUB_EOF) begin
                            dec_d.data  = 1'b1;
                            dec_d.value = EOF;
                        end else if (in_byte == SUB_ESC) begin
                            dec_d.data  = 1'b1;
                            dec_d.value = ESC;
                        end else begin
                            dec_d.abort = 1'b1;
                            dec_d.st    = ST_IDLE;
                        end
                    end
                    default: dec_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_start = dec_q.start;
    assign dec_data  = dec_q.data;
    assign dec_fin   = dec_q.fin;
    assign dec_abort = dec_q.abort;
    assign dec_byte  = dec_q.value;

    // R2: the decoder reports at most one event per cycle
    assert_one_event_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dec_start, dec_data, dec_fin, dec_abort}));

    // R8: no data or end event is reported without a frame open
    assert_no_event_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (dec_q.st == ST_IDLE && !in_valid) |=> !(dec_data || dec_fin || dec_abort));
endmodule

// File: rtl/sfr_crc.sv
module sfr_crc #(
    parameter int               BYTE_W = 8,
    parameter int               CRC_W  = 16,
    parameter [CRC_W-1:0]       POLY   = 16'h1021
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_in ^ (CRC_W'(data_in) << (CRC_W - BYTE_W));

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign stage[i+1] = stage[i][CRC_W-1] ? ((stage[i] << 1) ^ POLY)
                                              : (stage[i] << 1);
    end

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/sfr_track.sv
module sfr_track #(
    parameter int         BYTE_W   = 8,
    parameter int         CRC_W    = 16,
    parameter [CRC_W-1:0] CRC_SEED = 16'h1D0F,
    parameter [CRC_W-1:0] CRC_POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_start,
    input  logic              dec_data,
    input  logic              dec_fin,
    input  logic              dec_abort,
    input  logic [BYTE_W-1:0] dec_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              pkt_run,
    output logic              pkt_done,
    output logic              crc_err,
    output logic              frame_err
);
    localparam int HOLD  = CRC_W / BYTE_W;
    localparam int CNT_W = $clog2(HOLD + 1);

    typedef struct packed {
        logic                       run;
        logic [HOLD-1:0][BYTE_W-1:0] hold;
        logic [CNT_W-1:0]           cnt;
        logic [CRC_W-1:0]           crc;
        logic                       ovalid;
        logic [BYTE_W-1:0]          obyte;
        logic                       done;
        logic                       cerr;
        logic                       ferr;
    } trk_s;

    trk_s trk_d, trk_q;
    logic [CRC_W-1:0] crc_next;

    sfr_crc #(
        .BYTE_W (BYTE_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY)
    ) u_crc (
        .crc_in  (trk_q.crc),
        .data_in (trk_q.hold[HOLD-1]),
        .crc_out (crc_next)
    );

    always_comb begin
        trk_d        = trk_q;
        trk_d.ovalid = 1'b0;
        trk_d.done   = 1'b0;
        if (dec_start) begin
            trk_d.run  = 1'b1;
            trk_d.cnt  = '0;
            trk_d.crc  = CRC_SEED;
            trk_d.cerr = 1'b0;
            trk_d.ferr = 1'b0;
        end else if (trk_q.run && dec_data) begin
            trk_d.hold = {trk_q.hold[HOLD-2:0], dec_byte};
            if (trk_q.cnt == CNT_W'(HOLD)) begin
                trk_d.ovalid = 1'b1;
                trk_d.obyte  = trk_q.hold[HOLD-1];
                trk_d.crc    = crc_next;
            end else begin
                trk_d.cnt = trk_q.cnt + 1'b1;
            end
        end else if (trk_q.run && dec_fin) begin
            trk_d.run = 1'b0;
            if (trk_q.cnt != CNT_W'(HOLD)) begin
                trk_d.ferr = 1'b1;
            end else begin
                trk_d.done = 1'b1;
                trk_d.cerr = (trk_q.hold != trk_q.crc);
            end
        end else if (trk_q.run && dec_abort) begin
            trk_d.run  = 1'b0;
            trk_d.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign out_valid = trk_q.ovalid;
    assign out_byte  = trk_q.obyte;
    assign pkt_run   = trk_q.run;
    assign pkt_done  = trk_q.done;
    assign crc_err   = trk_q.cerr;
    assign frame_err = trk_q.ferr;

    // R3: payload is only presented while a frame is open
    assert_payload_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> pkt_run);

    // R5: completion closes the frame
    assert_done_closes_R5: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> !pkt_run && $fell(pkt_run));

    // R9: a completed frame is never a framing error
    assert_done_not_ferr_R9: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> !frame_err);

    // R1: a newly opened frame starts with clear flags
    assert_open_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_run) |-> !crc_err && !frame_err);

    // R6: an abort never coexists with completion
    assert_abort_no_done_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> !pkt_done && !pkt_run);
endmodule

// File: rtl/stuffed_frame_rx.sv
module stuffed_frame_rx #(
    parameter int          BYTE_W   = 8,
    parameter int          CRC_W    = 16,
    parameter [BYTE_W-1:0] SOF      = 8'h8E,
    parameter [BYTE_W-1:0] EOF      = 8'hAE,
    parameter [BYTE_W-1:0] ESC      = 8'h9E,
    parameter [BYTE_W-1:0] SUB_SOF  = 8'h81,
    parameter [BYTE_W-1:0] SUB_EOF  = 8'hA1,
    parameter [BYTE_W-1:0] SUB_ESC  = 8'h91,
    parameter [CRC_W-1:0]  CRC_SEED = 16'h1D0F,
    parameter [CRC_W-1:0]  CRC_POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              pkt_run,
    output logic              pkt_done,
    output logic              crc_err,
    output logic              frame_err
);
    logic              dec_start, dec_data, dec_fin, dec_abort;
    logic [BYTE_W-1:0] dec_byte;

    sfr_decode #(
        .BYTE_W  (BYTE_W),
        .SOF     (SOF),
        .EOF     (EOF),
        .ESC     (ESC),
        .SUB_SOF (SUB_SOF),
        .SUB_EOF (SUB_EOF),
        .SUB_ESC (SUB_ESC)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .dec_start (dec_start),
        .dec_data  (dec_data),
        .dec_fin   (dec_fin),
        .dec_abort (dec_abort),
        .dec_byte  (dec_byte)
    );

    sfr_track #(
        .BYTE_W   (BYTE_W),
        .CRC_W    (CRC_W),
        .CRC_SEED (CRC_SEED),
        .CRC_POLY (CRC_POLY)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .dec_start (dec_start),
        .dec_data  (dec_data),
        .dec_fin   (dec_fin),
        .dec_abort (dec_abort),
        .dec_byte  (dec_byte),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .pkt_run   (pkt_run),
        .pkt_done  (pkt_done),
        .crc_err   (crc_err),
        .frame_err (frame_err)
    );
endmodule

// File: tb/stuffed_frame_rx_test.sv
`timescale 1ns/1ps
module stuffed_frame_rx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid, pkt_run, pkt_done, crc_err, frame_err;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    stuffed_frame_rx uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .pkt_run(pkt_run),
        .pkt_done(pkt_done), .crc_err(crc_err), .frame_err(frame_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: payload scoreboard (R3) and completion counting (R5)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3: actual unexpected byte %0h expected none", out_byte);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (out_byte !== e) begin
                    errors++;
                    $display("FAIL R3: actual %0h expected %0h", out_byte, e);
                end
            end
        end
        if (!rst && pkt_done) done_cnt++;
    end

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic send_raw(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] b);
        if (b == 8'h8E) begin send_raw(8'h9E); send_raw(8'h81); end
        else if (b == 8'hAE) begin send_raw(8'h9E); send_raw(8'hA1); end
        else if (b == 8'h9E) begin send_raw(8'h9E); send_raw(8'h91); end
        else send_raw(b);
    endtask

    // driver: sends a complete frame and queues its expected payload
    task automatic send_frame(input logic [7:0] pl[$], input logic [15:0] crc_flip);
        logic [15:0] c;
        c = 16'h1D0F;
        foreach (pl[i]) begin
            c = crc_step(c, pl[i]);
            exp_q.push_back(pl[i]);
        end
        c = c ^ crc_flip;
        send_raw(8'h8E);
        foreach (pl[i]) send_data(pl[i]);
        send_data(c[15:8]);
        send_data(c[7:0]);
        send_raw(8'hAE);
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int d0;
        logic [7:0] pl[$];
        idle(3);
        // R10: reset state
        check("R10", {out_valid, pkt_run, pkt_done, crc_err, frame_err}, 5'b0);
        rst = 1'b0;
        idle(2);

        // R8: bytes outside a frame are ignored
        send_raw(8'h11); send_raw(8'hAE); send_raw(8'h9E); send_raw(8'h22);
        idle(3);
        check("R8 run", pkt_run, 1'b0);
        check("R8 done", done_cnt, 0);

        // R1, R3, R4, R5: plain frame
        d0 = done_cnt;
        pl = '{8'h01, 8'h02, 8'h03};
        fork
            send_frame(pl, 16'h0000);
            begin idle(4); check("R1 run high", pkt_run, 1'b1); end
        join
        check("R5 done", done_cnt - d0, 1);
        check("R5 run low", pkt_run, 1'b0);
        check("R4 crc ok", crc_err, 1'b0);
        check("R3 drained", exp_q.size(), 0);

        // R2: special values inside the payload
        d0 = done_cnt;
        pl = '{8'h8E, 8'hAE, 8'h9E, 8'h55, 8'h9E};
        send_frame(pl, 16'h0000);
        check("R2 done", done_cnt - d0, 1);
        check("R2 crc ok", crc_err, 1'b0);
        check("R2 drained", exp_q.size(), 0);

        // R4: corrupted CRC
        d0 = done_cnt;
        pl = '{8'hC3, 8'h3C};
        send_frame(pl, 16'h0100);
        check("R4 done on bad crc", done_cnt - d0, 1);
        check("R4 crc_err", crc_err, 1'b1);

        // R1: next start clears crc_err
        send_raw(8'h8E);
        idle(3);
        check("R1 clears crc_err", crc_err, 1'b0);
        check("R1 run", pkt_run, 1'b1);
        send_raw(8'hAE);
        idle(3);
        check("R9 short after clear", frame_err, 1'b1);

        // R4: frame carrying only its CRC
        d0 = done_cnt;
        pl = {};
        send_frame(pl, 16'h0000);
        check("R4 empty done", done_cnt - d0, 1);
        check("R4 empty crc ok", crc_err, 1'b0);
        check("R1 clears frame_err", frame_err, 1'b0);

        // R6: bad escape abandons the frame
        d0 = done_cnt;
        send_raw(8'h8E);
        send_raw(8'h10); send_raw(8'h20); send_raw(8'h30);
        exp_q.push_back(8'h10);
        send_raw(8'h9E); send_raw(8'h22);
        idle(3);
        check("R6 frame_err", frame_err, 1'b1);
        check("R6 run low", pkt_run, 1'b0);
        send_raw(8'h44); send_raw(8'h55); send_raw(8'h66); send_raw(8'hAE);
        idle(3);
        check("R6 no done", done_cnt - d0, 0);
        check("R6 drained", exp_q.size(), 0);

        // R7: restart inside a frame discards held-back bytes
        d0 = done_cnt;
        send_raw(8'h8E);
        send_raw(8'hA5); send_raw(8'h5A);
        pl = '{8'h77, 8'h88, 8'h99};
        send_frame(pl, 16'h0000);
        check("R7 done", done_cnt - d0, 1);
        check("R7 crc ok", crc_err, 1'b0);
        check("R7 drained", exp_q.size(), 0);

        // R9: frame with one decoded byte
        d0 = done_cnt;
        send_raw(8'h8E); send_raw(8'h05); send_raw(8'hAE);
        idle(3);
        check("R9 frame_err", frame_err, 1'b1);
        check("R9 no done", done_cnt - d0, 0);
        check("R9 crc_err low", crc_err, 1'b0);
        check("R9 run low", pkt_run, 1'b0);

        idle(4);
        finish_run();
    end
endmodule